// File: doc/BRIEF.md
# Bus Address-Range Watchpoint Unit

This block watches the stream of memory transactions that pass an arbiter and flags the ones that touch guarded memory. It has a set of independent watch units, four by default. Each unit holds a lowest and a highest address, a mask of access kinds and a mask of requesting clients. A transaction hits a unit when it lies inside the inclusive range, its kind is enabled and its client is enabled. On the first hit, the unit freezes a record of that access. The hit also sets a pending bit that feeds a shared interrupt.

The transaction input is a valid-qualified observation port with no ready signal. The unit only watches, so it never applies back-pressure and never stalls the fabric. Each cycle with `mon_valid` high is one transaction, and each such transaction is judged in that cycle. All programming pins and acknowledge pins are plain level or pulse inputs. The record of any unit is read through a combinational mux selected by `rd_unit`.

Software programs a unit with `cfg_we`. A hit raises the unit's pending bit, and the mask turns that into `irq`. Software then reads the record. A pulse on `gack` clears the pending bit, and a pulse on `uack_valid` re-arms the record so that the next hit is captured.

Top module: `bus_watch`

## Requirements
- R1: After reset every address bound and mask is zero, no pending bit is set, `irq` is 0 and no record is held. A transaction after reset therefore hits no unit until the unit is programmed.
- R2: A unit hits when all of these are true: `mon_valid` is 1, first <= `mon_addr` <= last (both bounds inclusive), bit `mon_op` of its kind mask is 1 (code 0 = read, code 1 = write), and bit `mon_client` of its client mask is 1. The hit sets the unit's `irq_pending` bit at the next clock edge.
- R3: A transaction below the range, above the range, of a disabled kind, from a disabled client, or with `mon_valid` low leaves the pending bits unchanged.
- R4: On a hit while no record is held, the unit latches the address, the kind, the size and the client, and `cap_held` becomes 1. `cap_clients` then ORs in a one-hot bit for the client of every later hit.
- R5: While a record is held, later hits do not change `cap_addr`, `cap_op`, `cap_size` or `cap_first`. A `uack_valid` pulse addressed to the unit, with no hit in that cycle, clears the record and `cap_held`.
- R6: `irq_status` is the pending bits ANDed with the mask register, and `irq` is the OR of `irq_status`. Pending bits are set whatever the mask holds.
- R7: A 1 in bit k of `gack` clears pending bit k. If unit k hits in the same cycle, the hit wins and the bit stays 1.
- R8: If a unit acknowledge and a hit fall on the same cycle, the record is rebuilt from the new hit alone.
- R9: A hit in one unit changes no pending bit or record of any other unit.
- R10: `cfg_field` selects what a write sets: 0 = first address, 1 = last address, 2 = kind mask, 3 = client mask. A transaction in the same cycle as the write is judged against the old value; from the next cycle on, the new value applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one field of one unit |
| cfg_unit | input | UNIT_W | Unit addressed by the write |
| cfg_field | input | 2 | Field selector (see R10) |
| cfg_wdata | input | ADDR_W | Write data; masks take the low bits |
| mask_we | input | 1 | Load the interrupt mask |
| mask_wdata | input | NUM_UNITS | New interrupt mask |
| gack | input | NUM_UNITS | Pending-bit clear pulses, one per unit |
| uack_valid | input | 1 | Re-arm the record of one unit |
| uack_unit | input | UNIT_W | Unit whose record is re-armed |
| mon_valid | input | 1 | Observed transaction present |
| mon_addr | input | ADDR_W | Transaction address |
| mon_op | input | OP_W | Transaction kind code |
| mon_client | input | CLIENT_W | Requesting client number |
| mon_size | input | SIZE_W | Transaction size code |
| rd_unit | input | UNIT_W | Unit whose record is shown |
| cap_held | output | 1 | Selected unit holds a record |
| cap_clients | output | NUM_CLIENTS | One-hot OR of clients that hit |
| cap_addr | output | ADDR_W | Address of the first hit |
| cap_op | output | OP_W | Kind of the first hit |
| cap_first | output | CLIENT_W | Client of the first hit |
| cap_size | output | SIZE_W | Size of the first hit |
| irq_pending | output | NUM_UNITS | Raw pending bits |
| irq_status | output | NUM_UNITS | Pending bits after the mask |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall on the same edge. The first pair is a fresh hit and the clear of that unit's pending bit. The bench provokes it by pulsing `gack` together with an in-range transaction, and passes it only if the bit is still set afterwards. The second pair is a fresh hit and the re-arm of that unit's record. The bench drives `uack_valid` together with a second hit, and passes it only if the record shows the second access alone, with a single client bit set. A configuration write that lands together with a transaction is judged on which bound applied.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_OPS  = 2'd2,
    FLD_CLI  = 2'd3
  } bw_field_e;
endpackage

// File: rtl/bw_unit.sv
module bw_unit
  import bw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OP_W     = 1,
  parameter int CLIENT_W = 4,
  parameter int SIZE_W   = 3,
  localparam int NUM_OPS     = 1 << OP_W,
  localparam int NUM_CLIENTS = 1 << CLIENT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_field,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  input  logic                   mon_valid,
  input  logic [ADDR_W-1:0]      mon_addr,
  input  logic [OP_W-1:0]        mon_op,
  input  logic [CLIENT_W-1:0]    mon_client,
  input  logic [SIZE_W-1:0]      mon_size,
  input  logic                   ack,
  output logic                   hit,
  output logic                   held,
  output logic [NUM_CLIENTS-1:0] rec_clients,
  output logic [ADDR_W-1:0]      rec_addr,
  output logic [OP_W-1:0]        rec_op,
  output logic [CLIENT_W-1:0]    rec_first,
  output logic [SIZE_W-1:0]      rec_size
);
  logic [ADDR_W-1:0]      lo_q, hi_q;
  logic [NUM_OPS-1:0]     ops_q;
  logic [NUM_CLIENTS-1:0] cli_q;
  logic [NUM_CLIENTS-1:0] cli_onehot;

  // Programming registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ops_q <= '0;
      cli_q <= '0;
    end else if (cfg_wr) begin
      case (bw_field_e'(cfg_field))
        FLD_LO:  lo_q  <= cfg_wdata;
        FLD_HI:  hi_q  <= cfg_wdata;
        FLD_OPS: ops_q <= cfg_wdata[NUM_OPS-1:0];
        default: cli_q <= cfg_wdata[NUM_CLIENTS-1:0];
      endcase
    end
  end

  // Match: inclusive range, kind enabled, client enabled
  assign cli_onehot = NUM_CLIENTS'(1) << mon_client;
  assign hit = mon_valid && (mon_addr >= lo_q) && (mon_addr <= hi_q)
               && ops_q[mon_op] && cli_q[mon_client];

  // Capture record: first hit frozen, client set accumulates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held        <= 1'b0;
      rec_clients <= '0;
      rec_addr    <= '0;
      rec_op      <= '0;
      rec_first   <= '0;
      rec_size    <= '0;
    end else if (hit) begin
      held <= 1'b1;
      if (!held || ack) begin
        rec_addr    <= mon_addr;
        rec_op      <= mon_op;
        rec_first   <= mon_client;
        rec_size    <= mon_size;
        rec_clients <= cli_onehot;
      end else begin
        rec_clients <= rec_clients | cli_onehot;
      end
    end else if (ack) begin
      held        <= 1'b0;
      rec_clients <= '0;
      rec_addr    <= '0;
      rec_op      <= '0;
      rec_first   <= '0;
      rec_size    <= '0;
    end
  end

  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) hit |=> held); // R4
  AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !ack) |=> ($stable(rec_addr) && $stable(rec_first) && $stable(rec_size))); // R5
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !held); // R5
  AST_ACK_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> $onehot0(rec_clients)); // R8
endmodule

// File: rtl/bw_irq.sv
module bw_irq #(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] hit,
  input  logic [NUM_UNITS-1:0] gack,
  input  logic                 mask_we,
  input  logic [NUM_UNITS-1:0] mask_wdata,
  output logic [NUM_UNITS-1:0] pending,
  output logic [NUM_UNITS-1:0] status,
  output logic                 irq
);
  logic [NUM_UNITS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      mask_q  <= '0;
    end else begin
      pending <= (pending & ~gack) | hit;  // set wins over clear
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status = pending & mask_q;
  assign irq    = |status;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_chk
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> pending[k]); // R7
    AST_GACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (gack[k] && !hit[k]) |=> !pending[k]); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending[k] && !hit[k]) |=> !pending[k]); // R3
  end
endmodule

// File: rtl/bus_watch.sv
module bus_watch #(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 32,
  parameter int OP_W      = 1,
  parameter int CLIENT_W  = 4,
  parameter int SIZE_W    = 3,
  localparam int UNIT_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int NUM_CLIENTS = 1 << CLIENT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [UNIT_W-1:0]      cfg_unit,
  input  logic [1:0]             cfg_field,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  input  logic                   mask_we,
  input  logic [NUM_UNITS-1:0]   mask_wdata,
  input  logic [NUM_UNITS-1:0]   gack,
  input  logic                   uack_valid,
  input  logic [UNIT_W-1:0]      uack_unit,
  input  logic                   mon_valid,
  input  logic [ADDR_W-1:0]      mon_addr,
  input  logic [OP_W-1:0]        mon_op,
  input  logic [CLIENT_W-1:0]    mon_client,
  input  logic [SIZE_W-1:0]      mon_size,
  input  logic [UNIT_W-1:0]      rd_unit,
  output logic                   cap_held,
  output logic [NUM_CLIENTS-1:0] cap_clients,
  output logic [ADDR_W-1:0]      cap_addr,
  output logic [OP_W-1:0]        cap_op,
  output logic [CLIENT_W-1:0]    cap_first,
  output logic [SIZE_W-1:0]      cap_size,
  output logic [NUM_UNITS-1:0]   irq_pending,
  output logic [NUM_UNITS-1:0]   irq_status,
  output logic                   irq
);
  logic [NUM_UNITS-1:0]   hit_v;
  logic [NUM_UNITS-1:0]   held_v;
  logic [NUM_CLIENTS-1:0] u_clients [NUM_UNITS];
  logic [ADDR_W-1:0]      u_addr    [NUM_UNITS];
  logic [OP_W-1:0]        u_op      [NUM_UNITS];
  logic [CLIENT_W-1:0]    u_first   [NUM_UNITS];
  logic [SIZE_W-1:0]      u_size    [NUM_UNITS];

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    bw_unit #(
      .ADDR_W(ADDR_W), .OP_W(OP_W), .CLIENT_W(CLIENT_W), .SIZE_W(SIZE_W)
    ) u_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_we && (cfg_unit == UNIT_W'(i))),
      .cfg_field  (cfg_field),
      .cfg_wdata  (cfg_wdata),
      .mon_valid  (mon_valid),
      .mon_addr   (mon_addr),
      .mon_op     (mon_op),
      .mon_client (mon_client),
      .mon_size   (mon_size),
      .ack        (uack_valid && (uack_unit == UNIT_W'(i))),
      .hit        (hit_v[i]),
      .held       (held_v[i]),
      .rec_clients(u_clients[i]),
      .rec_addr   (u_addr[i]),
      .rec_op     (u_op[i]),
      .rec_first  (u_first[i]),
      .rec_size   (u_size[i])
    );
  end

  bw_irq #(.NUM_UNITS(NUM_UNITS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit_v),
    .gack      (gack),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .pending   (irq_pending),
    .status    (irq_status),
    .irq       (irq)
  );

  assign cap_held    = held_v[rd_unit];
  assign cap_clients = u_clients[rd_unit];
  assign cap_addr    = u_addr[rd_unit];
  assign cap_op      = u_op[rd_unit];
  assign cap_first   = u_first[rd_unit];
  assign cap_size    = u_size[rd_unit];

  AST_HELD_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_v[0]) |-> irq_pending[0]); // R4
  AST_ISOLATED_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_v[1] && !irq_pending[1]) |=> !irq_pending[1]); // R9
endmodule

// File: tb/bus_watch_test.sv
module bus_watch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_unit = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_wdata = '0;
  logic [3:0]  gack = '0;
  logic        uack_valid = 1'b0;
  logic [1:0]  uack_unit = '0;
  logic        mon_valid = 1'b0;
  logic [31:0] mon_addr = '0;
  logic [0:0]  mon_op = '0;
  logic [3:0]  mon_client = '0;
  logic [2:0]  mon_size = '0;
  logic [1:0]  rd_unit = '0;
  logic        cap_held;
  logic [15:0] cap_clients;
  logic [31:0] cap_addr;
  logic [0:0]  cap_op;
  logic [3:0]  cap_first;
  logic [2:0]  cap_size;
  logic [3:0]  irq_pending, irq_status;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bus_watch uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector table: valid, address, kind, client, expected pending bits
  localparam logic        V_VAL [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,0};
  localparam logic [31:0] V_ADR [NV] = '{32'h1000, 32'h1FFF, 32'h0FFF, 32'h2000,
    32'h2000, 32'h2001, 32'h1500, 32'hFFFF_FFFF, 32'h3000, 32'h30FF, 32'h3010,
    32'h3010, 32'h1800};
  localparam logic        V_OP  [NV] = '{0,1,0,1,0,1,0,0,1,1,1,0,1};
  localparam logic [3:0]  V_CL  [NV] = '{0,7,0,1,1,1,3,3,5,9,6,5,0};
  localparam logic [3:0]  V_EXP [NV] = '{4'b0001, 4'b0001, 4'b0000, 4'b0010,
    4'b0000, 4'b0000, 4'b0101, 4'b0100, 4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000};
  localparam logic [3:0]  IRQ_MASK = 4'b0101;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int u, input int f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_unit = 2'(u); cfg_field = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one transaction, inputs dropped and result visible at the next falling edge
  task automatic xact(input logic v, input logic [31:0] a, input logic op, input logic [3:0] c, input logic [2:0] s);
    @(negedge clk);
    mon_valid = v; mon_addr = a; mon_op = op; mon_client = c; mon_size = s;
    @(negedge clk);
    mon_valid = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    gack = 4'hF;
    @(negedge clk);
    gack = 0;
    for (int u = 0; u < 4; u++) begin
      uack_valid = 1; uack_unit = 2'(u);
      @(negedge clk);
    end
    uack_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_pending == 0, "R1", 32'(irq_pending), 0);
    chk(irq == 0, "R1", 32'(irq), 0);
    for (int u = 0; u < 4; u++) begin
      rd_unit = 2'(u); #1;
      chk(cap_held == 0, "R1", 32'(cap_held), 0);
    end
    xact(1, 32'h0, 0, 0, 0);
    chk(irq_pending == 0, "R1 unprogrammed", 32'(irq_pending), 0);

    // programming: field 0 first, 1 last, 2 kind mask, 3 client mask
    cfg(0, 0, 32'h1000); cfg(0, 1, 32'h1FFF); cfg(0, 2, 32'h3); cfg(0, 3, 32'hFFFF);
    cfg(1, 0, 32'h2000); cfg(1, 1, 32'h2000); cfg(1, 2, 32'h2); cfg(1, 3, 32'hFFFF);
    cfg(2, 0, 32'h0);    cfg(2, 1, 32'hFFFF_FFFF); cfg(2, 2, 32'h1); cfg(2, 3, 32'h0008);
    cfg(3, 0, 32'h3000); cfg(3, 1, 32'h30FF); cfg(3, 2, 32'h2); cfg(3, 3, 32'h0220);
    @(negedge clk);
    mask_we = 1; mask_wdata = IRQ_MASK;
    @(negedge clk);
    mask_we = 0;

    // R2 R3 R9 R6: table walk
    for (int i = 0; i < NV; i++) begin
      xact(V_VAL[i], V_ADR[i], V_OP[i], V_CL[i], 3'd2);
      chk(irq_pending == V_EXP[i], "R2/R3/R9 pending", 32'(irq_pending), 32'(V_EXP[i]));
      chk(irq == |(V_EXP[i] & IRQ_MASK), "R6 irq", 32'(irq), 32'(|(V_EXP[i] & IRQ_MASK)));
      clear_all();
    end

    // R6: pending regardless of mask, status masked
    xact(1, 32'h3000, 1, 5, 0);
    chk(irq_pending == 4'b1000, "R6 pending", 32'(irq_pending), 32'h8);
    chk(irq_status == 0 && irq == 0, "R6 status", 32'(irq_status), 0);
    clear_all();

    // R4 R5: first hit frozen, clients accumulate
    xact(1, 32'h1234, 1, 2, 3);
    xact(1, 32'h1100, 0, 6, 1);
    rd_unit = 0; #1;
    chk(cap_held == 1, "R4 held", 32'(cap_held), 1);
    chk(cap_addr == 32'h1234, "R5 addr", cap_addr, 32'h1234);
    chk(cap_op == 1, "R5 op", 32'(cap_op), 1);
    chk(cap_first == 2, "R5 first", 32'(cap_first), 2);
    chk(cap_size == 3, "R5 size", 32'(cap_size), 3);
    chk(cap_clients == 16'h0044, "R4 clients", 32'(cap_clients), 32'h44);
    rd_unit = 1; #1;
    chk(cap_held == 0, "R9 other unit", 32'(cap_held), 0);
    rd_unit = 0;
    @(negedge clk);
    uack_valid = 1; uack_unit = 0;
    @(negedge clk);
    uack_valid = 0;
    chk(cap_held == 0 && cap_clients == 0, "R5 unit ack", 32'(cap_held), 0);

    // R7: clear and hit together, hit wins
    @(negedge clk);
    gack = 4'b0001; mon_valid = 1; mon_addr = 32'h1400; mon_op = 0; mon_client = 1;
    @(negedge clk);
    gack = 0; mon_valid = 0;
    chk(irq_pending[0] == 1, "R7 hit wins", 32'(irq_pending[0]), 1);
    @(negedge clk);
    gack = 4'b0001;
    @(negedge clk);
    gack = 0;
    chk(irq_pending[0] == 0, "R7 clear", 32'(irq_pending[0]), 0);
    @(negedge clk);
    uack_valid = 1; uack_unit = 0;
    @(negedge clk);
    uack_valid = 0;

    // R8: unit ack and hit together rebuild the record
    xact(1, 32'h1010, 0, 1, 1);
    @(negedge clk);
    uack_valid = 1; uack_unit = 0;
    mon_valid = 1; mon_addr = 32'h1020; mon_op = 1; mon_client = 4; mon_size = 5;
    @(negedge clk);
    uack_valid = 0; mon_valid = 0;
    chk(cap_held == 1 && cap_addr == 32'h1020, "R8 addr", cap_addr, 32'h1020);
    chk(cap_first == 4, "R8 first", 32'(cap_first), 4);
    chk(cap_clients == 16'h0010, "R8 clients", 32'(cap_clients), 32'h10);
    clear_all();

    // R10: write and transaction together use the old bound
    cfg(1, 1, 32'h2010);
    @(negedge clk);
    cfg_we = 1; cfg_unit = 1; cfg_field = 0; cfg_wdata = 32'h2009;
    mon_valid = 1; mon_addr = 32'h2008; mon_op = 1; mon_client = 0;
    @(negedge clk);
    cfg_we = 0; mon_valid = 0;
    chk(irq_pending == 4'b0010, "R10 old bound", 32'(irq_pending), 32'h2);
    clear_all();
    xact(1, 32'h2008, 1, 0, 0);
    chk(irq_pending == 0, "R10 new bound", 32'(irq_pending), 0);
    xact(1, 32'h2009, 1, 0, 0);
    chk(irq_pending == 4'b0010, "R10 new low edge", 32'(irq_pending), 32'h2);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule